// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds three banks of eight registers: address registers (18 bits), data registers (60 bits) and index registers (18 bits). Memory traffic comes only from writes to address registers. Writing address register n, for n from 1 to 5, fetches memory at that address into data register n. Writing address register 6 or 7 stores the current contents of data register 6 or 7 at that address. Address register 0 and data register 0 have no memory path, and index register 0 is a constant zero.

Issue logic writes and reads registers through one write port and one combinational read port. It watches a per-register pending vector so that it can stall any instruction that needs a data register whose load has not come back. Toward memory there is one request channel with a valid/ready handshake. Each request carries a tag equal to the register number. A response channel returns load data together with its tag.

Top module: `addr_xfer_regfile`

## Requirements
- R1: `wr_sel` selects the bank: 0 is address, 1 is data, 2 is index. Address and index registers keep only `wr_data[17:0]`, and data registers keep all 60 bits. `rd_data` shows the register selected by `rd_sel`/`rd_idx` in the same cycle, zero-extended, and `rd_sel` 3 reads zero.
- R2: Index register 0 always reads zero. A write to it is accepted and discarded.
- R3: Writing address register n (1..5) sets `pending[n]` after that clock edge. One cycle later a read request appears with `mem_req_write`=0, `mem_req_tag`=n and `mem_req_addr` equal to the written address, provided the channel is free.
- R4: A response with `mem_rsp_valid`=1 and tag n (1..5) loads `mem_rsp_data` into data register n and clears `pending[n]` on that edge. If a port write to the same data register happens in the same cycle, the response data is the value kept.
- R5: Writing address register 6 or 7 presents a write request with that tag and address. Its `mem_req_wdata` is the data register's value at the time of the address write, and later writes to that data register do not change it.
- R6: A write to address register 0 issues no request. Responses tagged 0, 6 or 7 change no data register and no pending bit.
- R7: At most one request is presented at a time. While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, data, tag and direction stay unchanged.
- R8: Accesses still waiting for the channel are presented one per accepted cycle, lowest register number first, whatever order they were written in.
- R9: After reset all registers read zero, `pending` is zero and no request is presented.
- R10: If an address register is written again before its earlier access has been presented, the two merge into one request that carries the newest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write bank: 0 address, 1 data, 2 index |
| wr_idx | input | 3 | Register number to write |
| wr_data | input | 60 | Write value |
| rd_sel | input | 2 | Read bank |
| rd_idx | input | 3 | Register number to read |
| rd_data | output | 60 | Read value |
| pending | output | 8 | Per data register: load in flight |
| mem_req_valid | output | 1 | Request presented |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_tag | output | 3 | Register number of the access |
| mem_req_addr | output | 18 | Memory address |
| mem_req_wdata | output | 60 | Store data |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_tag | input | 3 | Register number the response belongs to |
| mem_rsp_data | input | 60 | Load data |

## Verification
A wrong queue bit or a stale captured store value shows up at the request channel. It appears as a missing, duplicated or out-of-order tag, or as wrong write data, and it is visible one cycle after the channel becomes free. A wrong pending bit is visible on `pending` on the edge right after the address write or the response. A corrupted register shows on `rd_data` in the same cycle it is selected. Every such fault therefore surfaces within one or two cycles of the stimulus that exposes it.

// File: rtl/addr_xfer_regfile.sv
module addr_xfer_regfile #(
  parameter int AW    = 18,
  parameter int DW    = 60,
  parameter int NREG  = 8,
  parameter int LD_LO = 1,
  parameter int LD_HI = 5,
  parameter int ST_LO = 6,
  parameter int ST_HI = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [1:0]              rd_sel,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data,
  output logic [NREG-1:0]         pending,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [$clog2(NREG)-1:0] mem_req_tag,
  output logic [AW-1:0]           mem_req_addr,
  output logic [DW-1:0]           mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [$clog2(NREG)-1:0] mem_rsp_tag,
  input  logic [DW-1:0]           mem_rsp_data
);
  localparam int IW = $clog2(NREG);

  function automatic logic is_ld(input logic [IW-1:0] n);
    return int'(n) >= LD_LO && int'(n) <= LD_HI;
  endfunction
  function automatic logic is_st(input logic [IW-1:0] n);
    return int'(n) >= ST_LO && int'(n) <= ST_HI;
  endfunction

  logic [AW-1:0]   addr_q [NREG];
  logic [DW-1:0]   data_q [NREG];
  logic [AW-1:0]   xr_q   [NREG];
  logic [DW-1:0]   sbuf_q [NREG];
  logic [NREG-1:0] issue_q;

  logic a_we, d_we, x_we, rsp_hit, chan_free, pick_en;
  logic [IW-1:0] pick_idx;

  assign a_we      = wr_en && wr_sel == 2'd0;
  assign d_we      = wr_en && wr_sel == 2'd1;
  assign x_we      = wr_en && wr_sel == 2'd2 && wr_idx != '0;
  assign rsp_hit   = mem_rsp_valid && is_ld(mem_rsp_tag);
  assign chan_free = !mem_req_valid || mem_req_ready;
  assign pick_en   = chan_free && |issue_q;

  always_comb begin
    pick_idx = '0;
    for (int i = NREG-1; i >= 0; i--)
      if (issue_q[i]) pick_idx = i[IW-1:0];
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {{(DW-AW){1'b0}}, addr_q[rd_idx]};
      2'd1:    rd_data = data_q[rd_idx];
      2'd2:    rd_data = (rd_idx == '0) ? '0 : {{(DW-AW){1'b0}}, xr_q[rd_idx]};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
        xr_q[i]   <= '0;
        sbuf_q[i] <= '0;
      end
      issue_q <= '0;
      pending <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        logic hit;
        hit = wr_idx == i[IW-1:0];
        if (a_we && hit) addr_q[i] <= wr_data[AW-1:0];
        if (x_we && hit) xr_q[i] <= wr_data[AW-1:0];
        if (rsp_hit && mem_rsp_tag == i[IW-1:0]) data_q[i] <= mem_rsp_data;
        else if (d_we && hit) data_q[i] <= wr_data;
        if (a_we && hit && is_st(i[IW-1:0])) sbuf_q[i] <= data_q[i];
        if (a_we && hit && (is_ld(i[IW-1:0]) || is_st(i[IW-1:0]))) issue_q[i] <= 1'b1;
        else if (pick_en && pick_idx == i[IW-1:0]) issue_q[i] <= 1'b0;
        if (a_we && hit && is_ld(i[IW-1:0])) pending[i] <= 1'b1;
        else if (rsp_hit && mem_rsp_tag == i[IW-1:0]) pending[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_tag   <= '0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (pick_en) begin
      mem_req_valid <= 1'b1;
      mem_req_write <= is_st(pick_idx);
      mem_req_tag   <= pick_idx;
      mem_req_addr  <= addr_q[pick_idx];
      mem_req_wdata <= is_st(pick_idx) ? sbuf_q[pick_idx] : '0;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_wdata) && $stable(mem_req_tag) && $stable(mem_req_write));

  a_r3_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    a_we && is_ld(wr_idx) |=> pending[$past(wr_idx)]);

  a_r4_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && !(a_we && wr_idx == mem_rsp_tag) |=> !pending[$past(mem_rsp_tag)]);

  a_r6_tag_kind: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_write ? is_st(mem_req_tag) : is_ld(mem_req_tag)));

  a_r6_no_pending_unpaired: assert property (@(posedge clk) disable iff (!rst_n)
    !pending[0] && !pending[NREG-1] && !pending[ST_LO]);

  a_r2_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    xr_q[0] == '0);
endmodule

// File: tb/addr_xfer_regfile_test.sv
module addr_xfer_regfile_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, mem_req_ready, mem_rsp_valid;
  logic [1:0] wr_sel, rd_sel;
  logic [2:0] wr_idx, rd_idx, mem_rsp_tag;
  logic [59:0] wr_data, mem_rsp_data, rd_data;
  logic [7:0] pending;
  logic mem_req_valid, mem_req_write;
  logic [2:0] mem_req_tag;
  logic [17:0] mem_req_addr;
  logic [59:0] mem_req_wdata;

  int checks = 0;
  int errors = 0;

  addr_xfer_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .pending(pending), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_tag(mem_req_tag),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data));

  localparam int NV = 8;
  localparam logic [1:0]  T_SEL [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd1, 2'd0};
  localparam logic [2:0]  T_IDX [NV] = '{3'd0, 3'd0, 3'd7, 3'd1, 3'd0, 3'd7, 3'd3, 3'd0};
  localparam logic [59:0] T_DAT [NV] = '{60'h3FFFF, 60'hFEDCBA987654321, 60'h123456789ABCDEF,
                                         60'h1ABCD, 60'h1234, 60'hFFFF_FFC0_0015,
                                         60'h800000000000001, 60'h555_5AAAA};
  localparam logic [59:0] T_EXP [NV] = '{60'h3FFFF, 60'hFEDCBA987654321, 60'h123456789ABCDEF,
                                         60'h1ABCD, 60'h0, 60'h00015,
                                         60'h800000000000001, 60'h1AAAA};

  task automatic chk(input string req, input string what, input logic [59:0] act, input logic [59:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    rd_sel = '0; rd_idx = '0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_tag = '0; mem_rsp_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [2:0] idx, input logic [59:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [2:0] idx, output logic [59:0] v);
    rd_sel = sel; rd_idx = idx;
    #1 v = rd_data;
  endtask

  task automatic respond(input logic [2:0] tag, input logic [59:0] d);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_tag = tag; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic chk_req(input string req, input logic w, input logic [2:0] tag, input logic [17:0] a);
    chk(req, "req_valid", {59'd0, mem_req_valid}, 60'd1);
    chk(req, "req_write", {59'd0, mem_req_write}, {59'd0, w});
    chk(req, "req_tag", {57'd0, mem_req_tag}, {57'd0, tag});
    chk(req, "req_addr", {42'd0, mem_req_addr}, {42'd0, a});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [59:0] v;
    do_reset();

    // R9 reset state
    for (int b = 0; b < 3; b++) begin
      rd(b[1:0], 3'd5, v);
      chk("R9", "reg after reset", v, 60'd0);
    end
    chk("R9", "pending", {52'd0, pending}, 60'd0);
    chk("R9", "req_valid", {59'd0, mem_req_valid}, 60'd0);

    // R1/R2 table: write then read back
    for (int k = 0; k < NV; k++) begin
      do_write(T_SEL[k], T_IDX[k], T_DAT[k]);
      rd(T_SEL[k], T_IDX[k], v);
      chk((T_SEL[k] == 2'd2 && T_IDX[k] == 3'd0) ? "R2" : "R1", "readback", v, T_EXP[k]);
    end
    rd(2'd3, 3'd3, v);
    chk("R1", "unused bank", v, 60'd0);
    // R6: address register 0 writes above started nothing
    @(negedge clk);
    chk("R6", "no request from A0", {59'd0, mem_req_valid}, 60'd0);

    // R3/R4 load path
    do_reset();
    do_write(2'd0, 3'd3, 60'h155);
    chk("R3", "pending set", {52'd0, pending}, 60'h08);
    chk("R3", "not yet valid", {59'd0, mem_req_valid}, 60'd0);
    @(negedge clk);
    chk_req("R3", 1'b0, 3'd3, 18'h155);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3", "consumed", {59'd0, mem_req_valid}, 60'd0);
    chk("R4", "still pending", {52'd0, pending}, 60'h08);
    // response and port write collide: response wins
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_tag = 3'd3; mem_rsp_data = 60'hABCDEF012345678;
    wr_en = 1'b1; wr_sel = 2'd1; wr_idx = 3'd3; wr_data = 60'h111;
    @(negedge clk);
    mem_rsp_valid = 1'b0; wr_en = 1'b0;
    chk("R4", "pending cleared", {52'd0, pending}, 60'h00);
    rd(2'd1, 3'd3, v);
    chk("R4", "load data", v, 60'hABCDEF012345678);

    // R6 unpaired responses ignored
    do_write(2'd1, 3'd0, 60'h77);
    do_write(2'd1, 3'd6, 60'h66);
    respond(3'd0, 60'hDEAD);
    respond(3'd6, 60'hBEEF);
    rd(2'd1, 3'd0, v);
    chk("R6", "D0 untouched", v, 60'h77);
    rd(2'd1, 3'd6, v);
    chk("R6", "D6 untouched", v, 60'h66);
    chk("R6", "pending", {52'd0, pending}, 60'h00);

    // R5/R7 store captures data at address write, held while not ready
    do_reset();
    do_write(2'd1, 3'd6, 60'hAAAA_0000_1111);
    do_write(2'd0, 3'd6, 60'h2A);
    do_write(2'd1, 3'd6, 60'hBBBB_2222_3333);
    chk_req("R5", 1'b1, 3'd6, 18'h2A);
    chk("R5", "store data", mem_req_wdata, 60'hAAAA_0000_1111);
    chk("R5", "no pending for store", {52'd0, pending}, 60'h00);
    repeat (3) @(negedge clk);
    chk_req("R7", 1'b1, 3'd6, 18'h2A);
    chk("R7", "wdata held", mem_req_wdata, 60'hAAAA_0000_1111);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R7", "consumed", {59'd0, mem_req_valid}, 60'd0);

    // R8 ordering: A7, then A4, then A2 -> 7 (held), 2, 4
    do_reset();
    do_write(2'd0, 3'd7, 60'h70);
    do_write(2'd0, 3'd4, 60'h40);
    do_write(2'd0, 3'd2, 60'h20);
    chk_req("R8", 1'b1, 3'd7, 18'h70);
    chk("R8", "pending 2,4", {52'd0, pending}, 60'h14);
    mem_req_ready = 1'b1;
    @(negedge clk);
    chk_req("R8", 1'b0, 3'd2, 18'h20);
    @(negedge clk);
    chk_req("R8", 1'b0, 3'd4, 18'h40);
    @(negedge clk);
    chk("R8", "drained", {59'd0, mem_req_valid}, 60'd0);
    mem_req_ready = 1'b0;

    // R10 rewrite before presentation merges
    do_reset();
    do_write(2'd0, 3'd1, 60'h11);
    do_write(2'd0, 3'd5, 60'h100);
    do_write(2'd0, 3'd5, 60'h200);
    chk_req("R10", 1'b0, 3'd1, 18'h11);
    mem_req_ready = 1'b1;
    @(negedge clk);
    chk_req("R10", 1'b0, 3'd5, 18'h200);
    @(negedge clk);
    chk("R10", "single merged request", {59'd0, mem_req_valid}, 60'd0);
    mem_req_ready = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule